// File: doc/BRIEF.md
# Configuration Memory Bank Block Writer

This block sits behind a configuration command parser. When the parser has seen a write command for a configuration or block-memory bank, it pulses `start` with the geometry already decoded: bank index, memory kind, bank width, slice height and vertical start row. The block then takes the payload bytes through a valid/ready handshake. It turns each byte into eight single-bit write strobes, and every strobe carries the row and column address of that bit inside the chosen bank.

Bits leave most significant first. They fill the slice row by row: the column counter runs from zero up to width minus one and then wraps, and the row address is the start row plus the number of completed rows. A large bank can be loaded as several horizontal slices, each with its own start row. After the payload the block takes exactly two trailer bytes, which must both be zero. A non-zero trailer raises a sticky flag. When the second trailer byte has been taken, the block gives one `done` pulse. A geometry whose bit count is not a whole number of bytes is refused at start.

Top module: `cfg_bank_writer`

## Requirements
- R1: After reset `in_ready`, `wr_en`, `done`, `pad_err` and `param_err` are all low.
- R2: For width W and height H, exactly W*H/8 payload bytes are serialized. Exactly W*H write strobes are issued, and the next accepted bytes are treated as the trailer.
- R3: Payload byte k supplies strobes 8k to 8k+7. Bit 7 of the byte goes first and bit 0 last, on `wr_bit`.
- R4: Strobe number n carries `wr_col` = n mod W and `wr_row` = (offset + n div W) mod 2^16.
- R5: Every strobe carries the bank index and memory-kind flag that were present at the accepted `start`.
- R6: After a byte is accepted, its eight strobes come on eight consecutive cycles. `in_ready` is low during all of them.
- R7: Two trailer bytes are accepted after the payload. `done` is high for exactly one cycle, the cycle after the second trailer byte is accepted.
- R8: If either trailer byte is non-zero, `pad_err` goes high no later than the `done` cycle. It stays high until the next accepted `start` clears it.
- R9: A `start` whose W*H is not a multiple of 8 sets `param_err`. No strobe follows and `in_ready` stays low. The next accepted `start` clears `param_err`.
- R10: A `start` with W or H equal to zero sends the block straight to the trailer, with no strobes.
- R11: A `start` pulse while a transfer is in progress is ignored, and the new configuration values have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bank transfer (taken only when idle) |
| cfg_bank | input | BANK_W | Bank index for the transfer |
| cfg_is_bram | input | 1 | 1 selects block-memory banks, 0 configuration banks |
| cfg_width | input | DIM_W | Bank width in bits (columns) |
| cfg_height | input | DIM_W | Slice height in rows |
| cfg_offset | input | DIM_W | Start row of the slice |
| in_valid | input | 1 | Payload or trailer byte valid |
| in_data | input | DATA_W | Payload or trailer byte |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| wr_en | output | 1 | Bit write strobe |
| wr_bank | output | BANK_W | Bank index of the strobe |
| wr_is_bram | output | 1 | Memory kind of the strobe |
| wr_row | output | DIM_W | Row address of the bit |
| wr_col | output | DIM_W | Column address of the bit |
| wr_bit | output | 1 | Bit value |
| done | output | 1 | One-cycle completion pulse |
| pad_err | output | 1 | Sticky non-zero trailer flag |
| param_err | output | 1 | Sticky invalid-geometry flag |

## Verification
The end of the payload and the end of a row can fall on the same strobe, and the cursor then has to wrap the column and flag the final bit at once. The sweep covers every width from 1 to 8 with heights up to 6, so this case occurs many times. It is judged by checking that no strobe follows the last expected one and that the trailer bytes are taken as trailer. The second place where two functions meet is the last trailer byte. There `done` and a fresh `pad_err` can rise on the same edge. Cases with a non-zero second trailer check both outputs at the same sample point.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_SHIFT,
    ST_PAD0,
    ST_PAD1
  } cbw_state_e;

  // Whether W*H is a whole number of bytes depends only on the low three bits of each factor.
  function automatic logic geom_whole_bytes(input logic [2:0] w_lo, input logic [2:0] h_lo);
    logic [5:0] prod;
    prod = {3'b000, w_lo} * {3'b000, h_lo};
    return prod[2:0] == 3'd0;
  endfunction

endpackage

// File: rtl/cbw_cursor.sv
module cbw_cursor #(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [DIM_W-1:0] offset,
  output logic [DIM_W-1:0] col,
  output logic [DIM_W-1:0] row,
  output logic             last
);
  logic [DIM_W-1:0] col_q;
  logic [DIM_W-1:0] rows_done_q;
  logic             row_end;

  function automatic logic [DIM_W-1:0] abs_row(input logic [DIM_W-1:0] base,
                                               input logic [DIM_W-1:0] rel);
    return base + rel;
  endfunction

  assign row_end = (col_q == width - DIM_W'(1));
  assign last    = row_end && (rows_done_q == height - DIM_W'(1));
  assign col     = col_q;
  assign row     = abs_row(offset, rows_done_q);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      col_q       <= '0;
      rows_done_q <= '0;
    end else if (step) begin
      if (row_end) begin
        col_q       <= '0;
        rows_done_q <= rows_done_q + DIM_W'(1);
      end else begin
        col_q <= col_q + DIM_W'(1);
      end
    end
  end

  assert_col_below_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (col_q < width));

  assert_col_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && row_end && !load) |=> (col_q == '0));

endmodule

// File: rtl/cbw_shifter.sv
module cbw_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic              msb,
  output logic [$clog2(DATA_W)-1:0] idx,
  output logic              idx_last
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  assign msb      = sh_q[DATA_W-1];
  assign idx      = idx_q;
  assign idx_last = (idx_q == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= din;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      idx_q <= idx_last ? '0 : idx_q + IDX_W'(1);
    end
  end

  assert_load_restarts_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx_q == '0));

endmodule

// File: rtl/cbw_trailer.sv
module cbw_trailer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [DATA_W-1:0] byte_in,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err <= 1'b0;
    end else if (take && (byte_in != '0)) begin
      err <= 1'b1;
    end
  end

  assert_pad_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clear) |=> err);

  assert_zero_trailer_keeps_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!err && !(take && byte_in != '0)) |=> !err);

endmodule

// File: rtl/cfg_bank_writer.sv
module cfg_bank_writer
  import cbw_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic              cfg_is_bram,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [DIM_W-1:0]  cfg_offset,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic              wr_is_bram,
  output logic [DIM_W-1:0]  wr_row,
  output logic [DIM_W-1:0]  wr_col,
  output logic              wr_bit,
  output logic              done,
  output logic              pad_err,
  output logic              param_err
);
  localparam int IDX_W = $clog2(DATA_W);

  cbw_state_e        state_q;
  logic [BANK_W-1:0] bank_q;
  logic              bram_q;
  logic [DIM_W-1:0]  width_q, height_q, offset_q;
  logic              done_q, param_err_q;

  // Named internal events used by the assertions below.
  logic              start_take;
  logic              geom_ok;
  logic              geom_empty;
  logic              byte_take;
  logic              pad_take;
  logic              cur_last;
  logic              sh_msb;
  logic              sh_idx_last;
  logic [IDX_W-1:0]  sh_idx;

  assign start_take = start && (state_q == ST_IDLE);
  assign geom_ok    = geom_whole_bytes(cfg_width[2:0], cfg_height[2:0]);
  assign geom_empty = (cfg_width == '0) || (cfg_height == '0);
  assign in_ready   = (state_q == ST_DATA) || (state_q == ST_PAD0) || (state_q == ST_PAD1);
  assign byte_take  = in_valid && in_ready && (state_q == ST_DATA);
  assign pad_take   = in_valid && in_ready && (state_q != ST_DATA);
  assign wr_en      = (state_q == ST_SHIFT);
  assign wr_bank    = bank_q;
  assign wr_is_bram = bram_q;
  assign wr_bit     = sh_msb;
  assign done       = done_q;
  assign param_err  = param_err_q;

  cbw_cursor #(.DIM_W(DIM_W)) u_cursor (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_take),
    .step   (wr_en),
    .width  (width_q),
    .height (height_q),
    .offset (offset_q),
    .col    (wr_col),
    .row    (wr_row),
    .last   (cur_last)
  );

  cbw_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (byte_take),
    .din      (in_data),
    .shift    (wr_en),
    .msb      (sh_msb),
    .idx      (sh_idx),
    .idx_last (sh_idx_last)
  );

  cbw_trailer #(.DATA_W(DATA_W)) u_trailer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_take),
    .take    (pad_take),
    .byte_in (in_data),
    .err     (pad_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bank_q      <= '0;
      bram_q      <= 1'b0;
      width_q     <= '0;
      height_q    <= '0;
      offset_q    <= '0;
      done_q      <= 1'b0;
      param_err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            bank_q      <= cfg_bank;
            bram_q      <= cfg_is_bram;
            width_q     <= cfg_width;
            height_q    <= cfg_height;
            offset_q    <= cfg_offset;
            param_err_q <= !geom_ok;
            if (geom_ok) state_q <= geom_empty ? ST_PAD0 : ST_DATA;
          end
        end
        ST_DATA:  if (byte_take) state_q <= ST_SHIFT;
        ST_SHIFT: if (sh_idx_last) state_q <= cur_last ? ST_PAD0 : ST_DATA;
        ST_PAD0:  if (pad_take) state_q <= ST_PAD1;
        ST_PAD1: begin
          if (pad_take) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_ready_low_while_writing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !in_ready);

  assert_last_bit_on_byte_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cur_last) |-> sh_idx_last);

  assert_first_strobe_is_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |-> (sh_idx == '0));

  assert_done_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_write_after_param_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    param_err |-> (!wr_en && !in_ready));

  assert_bank_stable_in_transfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(wr_bank));

endmodule

// File: tb/cfg_bank_writer_tb.sv
module cfg_bank_writer_tb;
  localparam int DIM_W  = 16;
  localparam int BANK_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [BANK_W-1:0] cfg_bank = '0;
  logic              cfg_is_bram = 1'b0;
  logic [DIM_W-1:0]  cfg_width = '0, cfg_height = '0, cfg_offset = '0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready, wr_en, wr_is_bram, wr_bit, done, pad_err, param_err;
  logic [BANK_W-1:0] wr_bank;
  logic [DIM_W-1:0]  wr_row, wr_col;

  int nchk = 0, nfail = 0;
  int widx = 0, total = 0, cur_w = 1;
  logic [DIM_W-1:0]  cur_off = '0;
  logic [BANK_W-1:0] cur_bank = '0;
  logic              cur_bram = 1'b0;
  logic [7:0]        dbytes [0:7];

  always #2.5 clk = ~clk;

  cfg_bank_writer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_bank(cfg_bank), .cfg_is_bram(cfg_is_bram),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_offset(cfg_offset),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_is_bram(wr_is_bram), .wr_row(wr_row), .wr_col(wr_col),
    .wr_bit(wr_bit), .done(done), .pad_err(pad_err), .param_err(param_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Strobe monitor: expected address and bit are derived from the strobe index alone.
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (widx >= total) begin
        chk(1'b0, "R2", "unexpected strobe", widx, total);
      end else begin
        chk(wr_bit == dbytes[widx / 8][7 - (widx % 8)], "R3", "bit value", wr_bit, dbytes[widx / 8][7 - (widx % 8)]);
        chk(wr_col == DIM_W'(widx % cur_w), "R4", "column", wr_col, widx % cur_w);
        chk(wr_row == DIM_W'(cur_off + DIM_W'(widx / cur_w)), "R4", "row", wr_row, 32'(DIM_W'(cur_off + DIM_W'(widx / cur_w))));
        chk(wr_bank == cur_bank && wr_is_bram == cur_bram, "R5", "bank/kind", {wr_bank, wr_is_bram}, {cur_bank, cur_bram});
        chk(!in_ready, "R6", "ready during strobe", in_ready, 0);
      end
      widx++;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start(input int w, input int h, input int off, input int bank, input bit bram);
    @(negedge clk);
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h); cfg_offset = DIM_W'(off);
    cfg_bank = BANK_W'(bank); cfg_is_bram = bram;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input int w, input int h, input int off, input int bank, input bit bram,
                          input logic [7:0] p0, input logic [7:0] p1, input bit poke);
    int nbytes;
    nbytes = w * h / 8;
    for (int i = 0; i < 8; i++) dbytes[i] = 8'(w * 37 + h * 11 + i * 73 + off + 5);
    widx = 0; total = w * h; cur_w = (w == 0) ? 1 : w;
    cur_off = DIM_W'(off); cur_bank = BANK_W'(bank); cur_bram = bram;
    pulse_start(w, h, off, bank, bram);
    chk(!param_err, "R9", "param_err cleared by start", param_err, 0);
    chk(!pad_err, "R8", "pad_err cleared by start", pad_err, 0);
    for (int i = 0; i < nbytes; i++) begin
      send_byte(dbytes[i]);
      if (poke && i == 0) begin
        cfg_bank = ~cfg_bank; cfg_is_bram = ~cfg_is_bram; cfg_width = 16'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    send_byte(p0);
    chk(!done, "R7", "no done after first trailer", done, 0);
    send_byte(p1);
    chk(done, "R7", "done after second trailer", done, 1);
    chk(pad_err == (p0 != 0 || p1 != 0), "R8", "pad_err with done", pad_err, (p0 != 0 || p1 != 0));
    chk(widx == total, (w == 0 || h == 0) ? "R10" : "R2", "strobe count", widx, total);
    if (poke) chk(widx == total, "R11", "busy start ignored", widx, total);
    @(negedge clk);
    chk(!done, "R7", "done one cycle", done, 0);
    chk(pad_err == (p0 != 0 || p1 != 0), "R8", "pad_err sticky", pad_err, (p0 != 0 || p1 != 0));
  endtask

  task automatic bad_case(input int w, input int h);
    widx = 0; total = 0;
    pulse_start(w, h, 0, 1, 1'b0);
    chk(param_err, "R9", "param_err raised", param_err, 1);
    repeat (3) @(negedge clk);
    chk(!in_ready && param_err, "R9", "ready low, flag held", in_ready, 0);
    chk(widx == 0, "R9", "no strobes", widx, 0);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !wr_en && !done && !pad_err && !param_err, "R1", "reset state",
        {in_ready, wr_en, done, pad_err, param_err}, 0);

    run_case(8, 2, 5, 2, 1'b1, 8'h00, 8'h00, 1'b1);
    for (int w = 1; w <= 8; w++) begin
      for (int h = 1; h <= 6; h++) begin
        if ((w * h) % 8 == 0) begin
          run_case(w, h, (w * 3 + h) % 5 * 7, (w + h) % 4, 1'((w ^ h) & 1),
                   ((w + h) % 7 == 3) ? 8'h10 : 8'h00,
                   ((w + h) % 7 == 5) ? 8'h01 : 8'h00, 1'b0);
        end else if (h <= 3) begin
          bad_case(w, h);
        end
      end
    end
    run_case(8, 2, 16'hFFFF, 3, 1'b0, 8'h00, 8'h00, 1'b0);
    run_case(0, 5, 9, 1, 1'b1, 8'h00, 8'h80, 1'b0);
    run_case(4, 0, 2, 0, 1'b0, 8'h00, 8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule